// File: doc/BRIEF.md
# Frame-Slip Elastic Store

This block retimes a byte stream at E1 rate from the line side to the system side. A 64-byte circular store holds two 32-byte frames. Bytes enter on a write enable and leave on a read enable. Both ports run on one clock. The write and read pointers start half a buffer apart, so the store opens with one frame of margin in each direction.

When the two sides drift apart, the store corrects the drift by a whole frame at a time. If a lone write would fill the store completely, the read pointer jumps forward one frame and that frame is lost. If a lone read would empty the store, the read pointer falls back one frame and that frame is played again. A separate 4-bit counter records each kind of slip.

The fill level and both counters can be frozen into a pair of status bytes by pulsing a capture strobe. Software then reads these status bytes at leisure, for wander monitoring and delay estimates.

Top module: `frame_slip_store`

## Requirements
- R1: Bytes are read out in the order they were written, through a 64-entry store. The store contents clear to zero on reset. `rd_data` takes the byte at the read pointer on the clock edge where `rd_en` is high, and holds it otherwise.
- R2: The fill level is the write pointer minus the read pointer, modulo 64. After reset it is 32, with the write pointer at 32 and the read pointer at 0. A cycle with both enables high leaves it unchanged.
- R3: A negative slip happens on a write-only cycle that starts at fill 63. The read pointer advances 32 places, so one frame of stored bytes is dropped and the fill becomes 32.
- R4: A positive slip happens on a read-only cycle that starts at fill 1. That read returns its byte normally. The read pointer then moves back 31 places in net, so the previous frame is replayed and the fill becomes 32.
- R5: The negative-slip counter is 4 bits wide. It clears on reset, steps by one per negative slip and wraps from 15 to 0.
- R6: The positive-slip counter is 4 bits wide. It clears on reset, steps by one per positive slip and wraps from 15 to 0.
- R7: A clock edge with `snap_req` high loads the status bytes from the values held before that edge. `snap_fill` gets the fill level in bits 5:0 and zero in bits 7:6. `snap_slips` gets the negative count in bits 7:4 and the positive count in bits 3:0.
- R8: While `snap_req` is low, both status bytes keep their values, whatever the traffic. After reset both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, line side |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe, system side |
| rd_data | output | 8 | Registered byte read out |
| snap_req | input | 1 | Capture strobe for the status bytes |
| snap_fill | output | 8 | Captured fill level |
| snap_slips | output | 8 | Captured slip counts, negative high nibble |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- the read byte, the slip correction of the pointers and the counter step appear one edge after the cycle that enables them;
- the status bytes appear one edge after the cycle with the capture strobe.

Internal state is visible only through the capture path. The bench therefore drives each operation on a falling edge, follows each burst of traffic with one capture cycle, and compares the status bytes on the next falling edge. It compares read data on the falling edge that follows each read.

// File: rtl/esb_pkg.sv
package esb_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 6;
    localparam int CNT_W  = 4;
    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_NEG  = 2'd1,
        SLIP_POS  = 2'd2
    } slip_e;

    typedef struct packed {
        logic [STAT_W-1:0] fill_b;
        logic [STAT_W-1:0] slips_b;
    } snap_t;

    function automatic logic [PTR_W-1:0] fill_of(input logic [PTR_W-1:0] w,
                                                 input logic [PTR_W-1:0] r);
        return w - r;
    endfunction
endpackage

// File: rtl/esb_ptr_ctrl.sv
module esb_ptr_ctrl
    import esb_pkg::*;
#(
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] fill,
    output slip_e         slip
);
    localparam logic [PW-1:0] HALF = {1'b1, {(PW-1){1'b0}}};
    localparam logic [PW-1:0] ONE  = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] TOP  = {PW{1'b1}};

    logic [PW-1:0] rptr_nx;

    assign fill = fill_of(wptr, rptr);

    always_comb begin
        slip = SLIP_NONE;
        if (wr_en && !rd_en && fill == TOP)
            slip = SLIP_NEG;
        else if (rd_en && !wr_en && fill == ONE)
            slip = SLIP_POS;
    end

    always_comb begin
        rptr_nx = rptr + (rd_en ? ONE : '0);
        if (slip == SLIP_NEG)      rptr_nx = rptr_nx + HALF;
        else if (slip == SLIP_POS) rptr_nx = rptr_nx - HALF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= HALF;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= wptr + ONE;
            rptr <= rptr_nx;
        end
    end

    // R2: the fill level never reaches empty or full.
    a_r2_never_empty: assert property (@(posedge clk) disable iff (rst)
        fill != '0);
    // R2: balanced traffic leaves the fill level unchanged.
    a_r2_balanced: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(fill));
    // R3: a lone write at fill 63 drops a frame.
    a_r3_neg_slip: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && fill == TOP) |=> fill == HALF);
    // R4: a lone read at fill 1 replays a frame.
    a_r4_pos_slip: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && fill == ONE) |=> fill == HALF);
endmodule

// File: rtl/esb_ram.sv
module esb_ram
    import esb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wptr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [PW-1:0] rptr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << PW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) mem[wptr] <= wr_data;
            if (rd_en) rd_data <= mem[rptr];
        end
    end

    // R1: read data only changes on a read cycle.
    a_r1_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/esb_slip_cnt.sv
module esb_slip_cnt
    import esb_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R5/R6: one step per slip, wrapping modulo 2**CW.
    a_r5_r6_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> cnt == CW'($past(cnt) + 1'b1));
    a_r5_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/esb_snapshot.sv
module esb_snapshot
    import esb_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snap_req,
    input  logic [PW-1:0]     fill,
    input  logic [CW-1:0]     neg_cnt,
    input  logic [CW-1:0]     pos_cnt,
    output logic [STAT_W-1:0] snap_fill,
    output logic [STAT_W-1:0] snap_slips
);
    snap_t held, live;

    always_comb begin
        live.fill_b  = STAT_W'(fill);
        live.slips_b = STAT_W'({neg_cnt, pos_cnt});
    end

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (snap_req) held <= live;
    end

    assign snap_fill  = held.fill_b;
    assign snap_slips = held.slips_b;

    // R8: held values stay put without a capture strobe.
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !snap_req |=> $stable(held));
    // R7: bits above the fill level read zero.
    a_r7_pad_zero: assert property (@(posedge clk) disable iff (rst)
        snap_fill[STAT_W-1:PW] == '0);
endmodule

// File: rtl/frame_slip_store.sv
module frame_slip_store
    import esb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = PTR_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    input  logic              snap_req,
    output logic [STAT_W-1:0] snap_fill,
    output logic [STAT_W-1:0] snap_slips
);
    localparam int NDIR = 2;

    logic [PW-1:0] wptr, rptr, fill;
    slip_e         slip;
    logic [CW-1:0] cnt [NDIR];

    esb_ptr_ctrl #(.PW(PW)) u_ptr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .wptr(wptr), .rptr(rptr), .fill(fill), .slip(slip)
    );

    esb_ram #(.DW(DW), .PW(PW)) u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wptr(wptr), .wr_data(wr_data),
        .rd_en(rd_en), .rptr(rptr), .rd_data(rd_data)
    );

    // Direction 0 counts dropped frames, direction 1 counts replayed frames.
    for (genvar g = 0; g < NDIR; g++) begin : g_cnt
        localparam slip_e KIND = (g == 0) ? SLIP_NEG : SLIP_POS;
        esb_slip_cnt #(.CW(CW)) u_cnt (
            .clk(clk), .rst(rst), .inc(slip == KIND), .cnt(cnt[g])
        );
    end

    esb_snapshot #(.PW(PW), .CW(CW)) u_snap (
        .clk(clk), .rst(rst), .snap_req(snap_req), .fill(fill),
        .neg_cnt(cnt[0]), .pos_cnt(cnt[1]),
        .snap_fill(snap_fill), .snap_slips(snap_slips)
    );
endmodule

// File: tb/tb_frame_slip_store.sv
module tb_frame_slip_store;
    localparam int HALF_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, snap_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, snap_fill, snap_slips;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(HALF_NS) clk = ~clk;

    frame_slip_store dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .snap_req(snap_req), .snap_fill(snap_fill),
        .snap_slips(snap_slips)
    );

    // Each row: writes, reads, balanced cycles, expected fill, neg count, pos count.
    localparam int NV = 10;
    localparam int VEC [NV][6] = '{
        '{ 0,  0,  0, 32, 0, 0},
        '{10,  0,  0, 42, 0, 0},
        '{21,  0,  0, 63, 0, 0},
        '{ 1,  0,  0, 32, 1, 0},   // R3 drop at fill 63
        '{ 0, 31,  0,  1, 1, 0},
        '{ 0,  1,  0, 32, 1, 1},   // R4 replay at fill 1
        '{ 0,  0, 20, 32, 1, 1},   // R2 balanced traffic
        '{40,  0,  0, 40, 2, 1},
        '{ 0, 50,  0, 22, 2, 2},
        '{42,  0,  0, 32, 3, 2}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [7:0] d);
        wr_en = w; rd_en = r; wr_data = d; snap_req = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic snap();
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; snap_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_snap(input string req, input int f, input int ng, input int ps);
        snap();
        check(req, snap_fill, 8'(f));
        check(req, snap_slips, 8'({4'(ng), 4'(ps)}));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(2 * HALF_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R8 reset state of the status bytes, R1 reset read data
        check("R8", snap_fill, 8'h00);
        check("R8", snap_slips, 8'h00);
        check("R1", rd_data, 8'h00);

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < VEC[v][0]; i++) step(1'b1, 1'b0, 8'(i));
            for (int i = 0; i < VEC[v][1]; i++) step(1'b0, 1'b1, 8'h00);
            for (int i = 0; i < VEC[v][2]; i++) step(1'b1, 1'b1, 8'(i));
            expect_snap("R7", VEC[v][3], VEC[v][4], VEC[v][5]);
        end

        // R5 wrap: 13 more drops take the count from 3 through 15 to 0
        for (int k = 0; k < 13; k++)
            for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 8'h55);
        expect_snap("R5", 32, 0, 2);

        // R8: traffic without a strobe leaves the status bytes alone
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h11);
        check("R8", snap_fill, 8'd32);
        check("R8", snap_slips, 8'h02);
        expect_snap("R8", 37, 0, 2);

        // R6 wrap: 15 replays, then the 16th returns the count to 0
        do_reset();
        for (int k = 0; k < 15; k++)
            for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 8'h00);
        expect_snap("R6", 32, 0, 15);
        for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 8'h00);
        expect_snap("R6", 32, 0, 0);

        // R1 and R4: order of bytes and replay of the previous frame
        do_reset();
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 8'(i + 1));
        for (int i = 0; i < 65; i++) begin
            logic [7:0] e;
            if (i < 32)       e = 8'h00;
            else if (i < 63)  e = 8'(i - 31);
            else if (i == 63) e = 8'h00;
            else              e = 8'h01;
            step(1'b0, 1'b1, 8'h00);
            check((i >= 62) ? "R4" : "R1", rd_data, e);
        end

        // R3: the drop skips the zero frame, the next read is the first written byte
        do_reset();
        for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 8'(100 + i));
        step(1'b1, 1'b0, 8'd200);
        step(1'b0, 1'b1, 8'h00);
        check("R3", rd_data, 8'd100);
        expect_snap("R3", 31, 1, 0);

        finish_run();
    end
endmodule